// File: doc/BRIEF.md
# MESI Snooping Coherence Controller

This block keeps the coherence state of a small group of lines in one private cache attached to a shared snooping bus. The local processor sends read and write requests. Other caches' bus transactions arrive on a snoop port. For each line the block picks the next state among Invalid, Shared, Exclusive and Modified. It decides which bus command to issue: a read, a read-for-ownership, or an upgrade. It also raises a flush indication when dirty data has to be written back, and it stalls the processor until a missing access has been granted the bus and has completed.

During a snoop the block drives a wired "shared" line whenever it holds a valid copy of the line being read. It samples the same line from the other caches when its own read is granted. A read miss fills as Exclusive when no other cache claims a copy. A later write to that line then costs no bus transaction. Data arrays and the arbiter are outside the block. Arbitration is a plain request/grant pair, and a fill completes a fixed `FILL_LAT` cycles after its grant. A saturating counter of issued bus transactions shows the bus cost of an access sequence.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid (state code 0), the transaction counter is zero, and no bus request is raised.
- R2: A read to an Invalid line issues a read command (code 1). It completes `FILL_LAT` cycles after the grant cycle, and the line fills as Exclusive (code 2) if `shared_in` was low in the grant cycle or as Shared (code 1) if it was high.
- R3: A write to an Invalid line issues a read-for-ownership (code 2), completes `FILL_LAT` cycles after the grant, and leaves the line Modified (code 3).
- R4: A write to a Shared line issues an upgrade (code 3), completes in the cycle after the grant, and leaves the line Modified.
- R5: A write to an Exclusive line completes in the request cycle, leaves the line Modified, and raises no bus request.
- R6: Reads to Modified, Exclusive or Shared lines and writes to Modified lines complete in the request cycle without a bus request and without changing the state.
- R7: A snooped read (code 1) to a Modified line asserts `flush_out` and `shared_out` in that cycle, and the line becomes Shared.
- R8: A snooped read to an Exclusive or Shared line asserts `shared_out` without `flush_out` and leaves the line Shared. A snooped read to an Invalid line asserts neither.
- R9: A snooped read-for-ownership (code 2) or upgrade (code 3) leaves a valid line Invalid. A Modified line also asserts `flush_out` on a read-for-ownership.
- R10: A snoop takes priority over a local request in the same cycle. The local request stalls and is then re-evaluated against the updated state, so a pending write whose Shared copy was invalidated issues a read-for-ownership instead of an upgrade.
- R11: `txn_cnt` increments once per granted bus command and saturates at its all-ones value.
- R12: `bus_req` is low while the block is idle and in any cycle where a snoop is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Local access request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_idx | input | IDX_W | Line index of the local access |
| cpu_done | output | 1 | Access completes in this cycle |
| cpu_stall | output | 1 | Request present but not completing |
| bus_req | output | 1 | Request for the shared bus |
| bus_cmd | output | 2 | Command: 1 read, 2 read-for-ownership, 3 upgrade |
| bus_idx | output | IDX_W | Line index of the bus command |
| bus_gnt | input | 1 | Grant; the command is issued when `bus_req` and `bus_gnt` are both high |
| shared_in | input | 1 | Wired shared line from other caches |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_idx | input | IDX_W | Snooped line index |
| shared_out | output | 1 | This cache holds a valid copy of the snooped read |
| flush_out | output | 1 | Dirty line must be written back |
| line_state | output | 2*NLINES | Packed states: 0 I, 1 S, 2 E, 3 M |
| txn_cnt | output | CNT_W | Saturating count of issued bus commands |

## Verification
The embedded properties check the per-line snoop transitions on every cycle: invalidation on ownership requests and the drop to Shared on snooped reads. They also check that the counter saturates, that an upgrade completes one cycle after its grant unless a snoop intervenes, and that a write to an Exclusive line leaves the bus and the counter untouched. Only the bench scenarios show the end-to-end results. These are the Exclusive-versus-Shared fill chosen by the sampled shared line, the exact completion latencies, the bus cost of whole access sequences, and the switch from an upgrade to a read-for-ownership when a snoop invalidates a line that is waiting for the bus.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_t;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_RD   = 2'd1,
    CMD_RDX  = 2'd2,
    CMD_UPG  = 2'd3
  } bcmd_t;
endpackage

// File: rtl/mesi_line.sv
module mesi_line
  import mesi_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  snp_hit,
  input  bcmd_t snp_cmd,
  input  logic  loc_we,
  input  mesi_t loc_st,
  output mesi_t st_o,
  output logic  shared_o,
  output logic  flush_o
);
  mesi_t st_q, st_d;
  logic  st_en;

  always_comb begin
    st_d = st_q;
    if (snp_hit) begin
      case (snp_cmd)
        CMD_RD:           if (st_q != ST_I) st_d = ST_S;
        CMD_RDX, CMD_UPG: st_d = ST_I;
        default:          st_d = st_q;
      endcase
    end else if (loc_we) begin
      st_d = loc_st;
    end
  end

  assign st_en = snp_hit | loc_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= ST_I;
    else if (st_en) st_q <= st_d;
  end

  assign st_o     = st_q;
  assign shared_o = snp_hit && (snp_cmd == CMD_RD) && (st_q != ST_I);
  assign flush_o  = snp_hit && (st_q == ST_M) &&
                    ((snp_cmd == CMD_RD) || (snp_cmd == CMD_RDX));

  // R9: ownership snoops kill any copy
  assert_own_snoop_kills_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_hit && ((snp_cmd == CMD_RDX) || (snp_cmd == CMD_UPG))) |=> (st_q == ST_I));

  // R7 / R8: snooped read leaves a valid copy Shared
  assert_read_snoop_shares_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_hit && (snp_cmd == CMD_RD) && (st_q != ST_I)) |=> (st_q == ST_S));
endmodule

// File: rtl/mesi_txn_ctr.sv
module mesi_txn_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = inc && (cnt_q != CNT_MAX);

  always_comb begin
    cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R11: saturation holds
  assert_ctr_saturates_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  // R11: each issue counts by one below saturation
  assert_ctr_steps_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && (cnt_q != CNT_MAX)) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
  import mesi_pkg::*;
#(
  parameter int IDX_W    = 2,
  parameter int FILL_LAT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic             cpu_we,
  input  logic [IDX_W-1:0] cpu_idx,
  input  logic             snp_valid,
  input  logic             bus_gnt,
  input  logic             shared_in,
  input  mesi_t            cur_st,
  output logic [IDX_W-1:0] sel_idx,
  output logic             loc_we,
  output logic [IDX_W-1:0] loc_idx,
  output mesi_t            loc_st,
  output logic             cpu_done,
  output logic             bus_req,
  output bcmd_t            bus_cmd,
  output logic [IDX_W-1:0] bus_idx,
  output logic             issue,
  output logic             idle_o
);
  localparam int LAT_W = $clog2(FILL_LAT + 1);
  localparam logic [LAT_W-1:0] LAT_LOAD = LAT_W'(FILL_LAT - 1);

  typedef enum logic [1:0] {F_IDLE, F_WAIT, F_FILL} fst_t;

  fst_t             fst_q, fst_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             we_q, we_d;
  bcmd_t            cmd_q, cmd_d;
  logic             sh_q, sh_d;
  logic [LAT_W-1:0] cnt_q, cnt_d;
  bcmd_t            miss_cmd;

  assign sel_idx = (fst_q == F_IDLE) ? cpu_idx : idx_q;
  assign loc_idx = sel_idx;
  assign bus_idx = idx_q;
  assign idle_o  = (fst_q == F_IDLE);

  always_comb begin
    if (!we_q)               miss_cmd = CMD_RD;
    else if (cur_st == ST_S) miss_cmd = CMD_UPG;
    else                     miss_cmd = CMD_RDX;
  end

  always_comb begin
    fst_d    = fst_q;
    idx_d    = idx_q;
    we_d     = we_q;
    cmd_d    = cmd_q;
    sh_d     = sh_q;
    cnt_d    = cnt_q;
    loc_we   = 1'b0;
    loc_st   = cur_st;
    cpu_done = 1'b0;
    bus_req  = 1'b0;
    bus_cmd  = CMD_NONE;
    issue    = 1'b0;
    case (fst_q)
      F_IDLE: begin
        if (cpu_req && !snp_valid) begin
          if (!cpu_we && (cur_st != ST_I)) begin
            cpu_done = 1'b1;
          end else if (cpu_we && (cur_st == ST_M)) begin
            cpu_done = 1'b1;
          end else if (cpu_we && (cur_st == ST_E)) begin
            cpu_done = 1'b1;
            loc_we   = 1'b1;
            loc_st   = ST_M;
          end else begin
            fst_d = F_WAIT;
            idx_d = cpu_idx;
            we_d  = cpu_we;
          end
        end
      end
      F_WAIT: begin
        bus_cmd = miss_cmd;
        if (!snp_valid) begin
          bus_req = 1'b1;
          if (bus_gnt) begin
            issue = 1'b1;
            cmd_d = miss_cmd;
            sh_d  = shared_in;
            cnt_d = (miss_cmd == CMD_UPG) ? '0 : LAT_LOAD;
            fst_d = F_FILL;
          end
        end
      end
      F_FILL: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else if (!snp_valid) begin
          cpu_done = 1'b1;
          loc_we   = 1'b1;
          loc_st   = (cmd_q == CMD_RD) ? (sh_q ? ST_S : ST_E) : ST_M;
          fst_d    = F_IDLE;
        end
      end
      default: fst_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fst_q <= F_IDLE;
      idx_q <= '0;
      we_q  <= 1'b0;
      cmd_q <= CMD_NONE;
      sh_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      fst_q <= fst_d;
      idx_q <= idx_d;
      we_q  <= we_d;
      cmd_q <= cmd_d;
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  // R4: an upgrade completes one cycle after its grant unless a snoop intervenes
  assert_upg_next_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && (bus_cmd == CMD_UPG)) |=> (cpu_done || snp_valid));
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int NLINES   = 4,
  parameter int FILL_LAT = 3,
  parameter int CNT_W    = 8,
  localparam int IDX_W   = $clog2(NLINES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cpu_req,
  input  logic                  cpu_we,
  input  logic [IDX_W-1:0]      cpu_idx,
  output logic                  cpu_done,
  output logic                  cpu_stall,
  output logic                  bus_req,
  output logic [1:0]            bus_cmd,
  output logic [IDX_W-1:0]      bus_idx,
  input  logic                  bus_gnt,
  input  logic                  shared_in,
  input  logic                  snp_valid,
  input  logic [1:0]            snp_cmd,
  input  logic [IDX_W-1:0]      snp_idx,
  output logic                  shared_out,
  output logic                  flush_out,
  output logic [2*NLINES-1:0]   line_state,
  output logic [CNT_W-1:0]      txn_cnt
);
  mesi_t             st_arr [NLINES];
  logic [NLINES-1:0] sh_vec, fl_vec;
  logic [IDX_W-1:0]  sel_idx, loc_idx;
  logic              loc_we, issue, fsm_idle;
  mesi_t             loc_st, cur_st;
  bcmd_t             bus_cmd_e;

  mesi_req_fsm #(.IDX_W(IDX_W), .FILL_LAT(FILL_LAT)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_idx(cpu_idx),
    .snp_valid(snp_valid), .bus_gnt(bus_gnt), .shared_in(shared_in),
    .cur_st(cur_st), .sel_idx(sel_idx),
    .loc_we(loc_we), .loc_idx(loc_idx), .loc_st(loc_st),
    .cpu_done(cpu_done), .bus_req(bus_req), .bus_cmd(bus_cmd_e),
    .bus_idx(bus_idx), .issue(issue), .idle_o(fsm_idle)
  );

  assign cur_st    = st_arr[sel_idx];
  assign bus_cmd   = bus_cmd_e;
  assign cpu_stall = cpu_req && !cpu_done;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic hit_g, we_g;
    assign hit_g = snp_valid && (snp_idx == IDX_W'(g));
    assign we_g  = loc_we && (loc_idx == IDX_W'(g));
    mesi_line u_line (
      .clk(clk), .rst_n(rst_n),
      .snp_hit(hit_g), .snp_cmd(bcmd_t'(snp_cmd)),
      .loc_we(we_g), .loc_st(loc_st),
      .st_o(st_arr[g]), .shared_o(sh_vec[g]), .flush_o(fl_vec[g])
    );
    assign line_state[2*g +: 2] = st_arr[g];
  end

  assign shared_out = |sh_vec;
  assign flush_out  = |fl_vec;

  mesi_txn_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .inc(issue), .cnt_o(txn_cnt)
  );

  // R5: a write to an Exclusive line finishes at once and costs no bus traffic
  assert_excl_write_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_idle && cpu_req && cpu_we && !snp_valid && (cur_st == ST_E))
      |-> cpu_done ##1 (!bus_req && $stable(txn_cnt)));
endmodule

// File: tb/mesi_line_ctrl_tb_top.sv
module mesi_line_ctrl_tb_top;
  localparam int NLINES   = 4;
  localparam int FILL_LAT = 3;
  localparam int CNT_W    = 8;
  localparam int IDX_W    = 2;
  localparam int LAT_MISS = 2 + FILL_LAT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [IDX_W-1:0] cpu_idx = '0;
  logic cpu_done, cpu_stall, bus_req;
  logic [1:0] bus_cmd;
  logic [IDX_W-1:0] bus_idx;
  logic bus_gnt = 1'b1, shared_in = 1'b0;
  logic snp_valid = 1'b0;
  logic [1:0] snp_cmd = 2'd0;
  logic [IDX_W-1:0] snp_idx = '0;
  logic shared_out, flush_out;
  logic [2*NLINES-1:0] line_state;
  logic [CNT_W-1:0] txn_cnt;

  always #2.5 clk = ~clk;

  mesi_line_ctrl #(.NLINES(NLINES), .FILL_LAT(FILL_LAT), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_idx(cpu_idx),
    .cpu_done(cpu_done), .cpu_stall(cpu_stall),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_idx(bus_idx),
    .bus_gnt(bus_gnt), .shared_in(shared_in),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_idx(snp_idx),
    .shared_out(shared_out), .flush_out(flush_out),
    .line_state(line_state), .txn_cnt(txn_cnt)
  );

  int checks = 0;
  int errors = 0;
  int exp_txn = 0;
  bit done_flag = 1'b0;

  typedef struct packed {
    logic       snp;
    logic [1:0] idx;
    logic [1:0] op;
    logic       sh;
    logic [1:0] ecmd;
    logic       esh;
    logic       efl;
    logic [1:0] est;
    logic [3:0] elat;
    logic       ed;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 2'd0, 1'b0, 2'd1, 1'b0, 1'b0, 2'd2, 4'(LAT_MISS), 1'b1, 4'd2},  // R2 fill E
    '{1'b0, 2'd0, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 2'd3, 4'd1, 1'b0, 4'd5},          // R5 silent
    '{1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd3, 4'd1, 1'b0, 4'd6},          // R6 M read
    '{1'b1, 2'd0, 2'd1, 1'b0, 2'd0, 1'b1, 1'b1, 2'd1, 4'd0, 1'b0, 4'd7},          // R7
    '{1'b0, 2'd1, 2'd0, 1'b1, 2'd1, 1'b0, 1'b0, 2'd1, 4'(LAT_MISS), 1'b1, 4'd2},  // R2 fill S
    '{1'b0, 2'd1, 2'd1, 1'b0, 2'd3, 1'b0, 1'b0, 2'd3, 4'd3, 1'b1, 4'd4},          // R4
    '{1'b1, 2'd1, 2'd2, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 4'd0, 1'b0, 4'd9},          // R9 M
    '{1'b0, 2'd2, 2'd1, 1'b0, 2'd2, 1'b0, 1'b0, 2'd3, 4'(LAT_MISS), 1'b1, 4'd3},  // R3
    '{1'b0, 2'd3, 2'd0, 1'b0, 2'd1, 1'b0, 1'b0, 2'd2, 4'(LAT_MISS), 1'b1, 4'd2},  // R2
    '{1'b1, 2'd3, 2'd1, 1'b0, 2'd0, 1'b1, 1'b0, 2'd1, 4'd0, 1'b0, 4'd8},          // R8 E
    '{1'b0, 2'd3, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd1, 4'd1, 1'b0, 4'd6},          // R6 S read
    '{1'b1, 2'd3, 2'd3, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 4'd0, 1'b0, 4'd9},          // R9 upgrade
    '{1'b1, 2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 4'd0, 1'b0, 4'd8},          // R8 I
    '{1'b0, 2'd2, 2'd1, 1'b0, 2'd0, 1'b0, 1'b0, 2'd3, 4'd1, 1'b0, 4'd6},          // R6 M write
    '{1'b1, 2'd0, 2'd2, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 4'd0, 1'b0, 4'd9}           // R9 S
  };

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic int st_of(input int idx);
    return int'(line_state[2*idx +: 2]);
  endfunction

  task automatic access(input int idx, input bit we, input bit sh,
                        output int cmd_seen, output int lat);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_idx = IDX_W'(idx); shared_in = sh;
    cmd_seen = 0; lat = 0;
    for (int k = 0; k < 40; k++) begin
      #1;
      lat++;
      if (bus_req && bus_gnt && cmd_seen == 0) cmd_seen = int'(bus_cmd);
      if (cpu_done) break;
      @(negedge clk);
    end
    @(negedge clk);
    cpu_req = 1'b0; shared_in = 1'b0;
    #1;
  endtask

  task automatic snoop(input int idx, input int cmd, output bit sh, output bit fl);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = 2'(cmd); snp_idx = IDX_W'(idx);
    #1;
    sh = shared_out; fl = flush_out;
    @(negedge clk);
    snp_valid = 1'b0;
    #1;
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      report();
    end
  end

  initial begin
    int cmd_seen, lat;
    bit sh, fl;
    string rq;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(line_state == '0, "R1", "line_state", int'(line_state), 0);
    chk(txn_cnt == '0, "R1", "txn_cnt", int'(txn_cnt), 0);
    chk(!bus_req, "R1", "bus_req", int'(bus_req), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(line_state == '0, "R1", "state after release", int'(line_state), 0);
    chk(!bus_req, "R12", "bus_req idle", int'(bus_req), 0);

    for (int v = 0; v < NV; v++) begin
      rq = $sformatf("R%0d", VECS[v].rq);
      if (!VECS[v].snp) begin
        access(int'(VECS[v].idx), VECS[v].op[0], VECS[v].sh, cmd_seen, lat);
        chk(cmd_seen == int'(VECS[v].ecmd), rq, $sformatf("v%0d bus cmd", v),
            cmd_seen, int'(VECS[v].ecmd));
        chk(lat == int'(VECS[v].elat), rq, $sformatf("v%0d latency", v),
            lat, int'(VECS[v].elat));
        exp_txn += int'(VECS[v].ed);
        // R11: running transaction count
        chk(int'(txn_cnt) == exp_txn, "R11", $sformatf("v%0d txn_cnt", v),
            int'(txn_cnt), exp_txn);
      end else begin
        snoop(int'(VECS[v].idx), int'(VECS[v].op), sh, fl);
        chk(sh == VECS[v].esh, rq, $sformatf("v%0d shared_out", v), int'(sh), int'(VECS[v].esh));
        chk(fl == VECS[v].efl, rq, $sformatf("v%0d flush_out", v), int'(fl), int'(VECS[v].efl));
      end
      chk(st_of(int'(VECS[v].idx)) == int'(VECS[v].est), rq, $sformatf("v%0d state", v),
          st_of(int'(VECS[v].idx)), int'(VECS[v].est));
    end

    // R10: snoop and local read to line 2 (Modified) in the same cycle
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_idx = 2'd2;
    snp_valid = 1'b1; snp_cmd = 2'd1; snp_idx = 2'd2;
    #1;
    chk(!cpu_done && cpu_stall, "R10", "local stalled by snoop", int'(cpu_done), 0);
    chk(flush_out, "R7", "flush on same-cycle snoop", int'(flush_out), 1);
    @(negedge clk);
    snp_valid = 1'b0;
    #1;
    chk(cpu_done, "R10", "re-evaluated read hit", int'(cpu_done), 1);
    chk(st_of(2) == 1, "R10", "line 2 shared", st_of(2), 1);
    @(negedge clk);
    cpu_req = 1'b0;

    // R10: pending upgrade turns into read-for-ownership after invalidation
    bus_gnt = 1'b0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_idx = 2'd2;
    @(negedge clk); #1;
    chk(bus_req && bus_cmd == 2'd3, "R4", "upgrade requested", int'(bus_cmd), 3);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = 2'd2; snp_idx = 2'd2;
    #1;
    chk(!bus_req, "R12", "bus_req dropped in snoop", int'(bus_req), 0);
    @(negedge clk);
    snp_valid = 1'b0;
    #1;
    chk(st_of(2) == 0, "R9", "line 2 invalidated", st_of(2), 0);
    chk(bus_req && bus_cmd == 2'd2, "R10", "command became RDX", int'(bus_cmd), 2);
    bus_gnt = 1'b1;
    lat = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); #1;
      lat++;
      if (cpu_done) break;
    end
    chk(lat == FILL_LAT, "R3", "fill latency after grant", lat, FILL_LAT);
    @(negedge clk);
    cpu_req = 1'b0;
    #1;
    exp_txn++;
    chk(st_of(2) == 3, "R3", "line 2 modified", st_of(2), 3);
    chk(int'(txn_cnt) == exp_txn, "R11", "txn after RDX", int'(txn_cnt), exp_txn);

    // R11: saturation
    for (int n = 0; n < 260; n++) begin
      access(0, 1'b1, 1'b0, cmd_seen, lat);
      snoop(0, 2, sh, fl);
    end
    chk(txn_cnt == {CNT_W{1'b1}}, "R11", "saturated count", int'(txn_cnt), (1 << CNT_W) - 1);
    chk(!bus_req, "R12", "bus_req idle at end", int'(bus_req), 0);

    done_flag = 1'b1;
    report();
  end
endmodule